// File: doc/BRIEF.md
# PAM-4 Level Decoder with Parallel PRBS7 Checker

This block sits behind the three threshold comparators of a four-level receiver. It runs at one eighth of the symbol rate, so each clock brings eight symbols: three comparator bits per symbol, one from each threshold slicer. Each symbol's comparator pattern is a thermometer code. The block turns it into a plain binary level from 0 (lowest) to 3 (highest) and presents the sixteen decoded bits on a registered output.

The same decoded bits are treated as one serial stream. Within a symbol the MSB comes before the LSB, and symbol 0 is the earliest of the eight. The stream is checked against a 2^7-1 pseudo-random sequence built on x^7 + x^6 + 1. Each bit is predicted from the seven received bits before it, so the checker locks by itself after seven bits and needs no seed. The block gives one error flag per clock covering all eight symbols. The flag is a typical input for a bit-error counter elsewhere on the chip.

Top module: `pam4_prbs_rx`

## Requirements
- R1: For a valid cycle, symbol k's level appears on `level_o[2k+1:2k]` one clock later. The comparator pattern {hi,mid,lo} decodes as 000 to 0, 001 to 1, 011 to 2 and 111 to 3.
- R2: A non-thermometer pattern on any symbol (010, 100, 101, 110) decodes to the number of ones in the pattern. It also sets `err_o` on the next clock, unless R6 or R7 suppresses the flag.
- R3: While `valid` is low, `level_o` keeps its value and the checker history is not advanced.
- R4: In the serial order (symbol 0 first, MSB before LSB), received bit n must equal bit n-7 XOR bit n-6. History carries across clock boundaries. Any mismatch among the sixteen bits sets `err_o` one clock after the valid cycle.
- R5: An uninterrupted, error-free PRBS7 stream keeps `err_o` low in every cycle, whatever the starting phase of the sequence.
- R6: `err_o` stays low for the first valid cycle after reset, and for the first valid cycle after `valid` rises, whatever the data.
- R7: `err_o` is low one clock after any cycle with `valid` low.
- R8: While `rst_n` is low, `level_o` is zero and `err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock, one eighth of the symbol rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Comparator samples in this cycle are meaningful |
| thr_lo | input | 8 | Lowest-threshold comparator output, bit k for symbol k |
| thr_mid | input | 8 | Middle-threshold comparator output |
| thr_hi | input | 8 | Highest-threshold comparator output |
| level_o | output | 16 | Decoded levels, symbol k on bits 2k+1:2k |
| err_o | output | 1 | Combined error for the eight symbols of the previous valid cycle |

## Verification
The bench injects single bit flips inside a cycle and at bit 0 of a cycle. A checker that predicted from the wrong taps, reversed the MSB/LSB order, or dropped the history between clocks would miss the boundary flip or report errors on a clean stream. Bubble patterns are placed on a clean PRBS stream. A decoder that mapped them to a fixed level would show the wrong level, and one that ignored them would leave `err_o` low. Gaps in `valid` test two things: that the first cycle after a rise is never flagged, and that idle cycles neither change `level_o` nor raise a flag.

// File: rtl/pam4_prbs_rx.sv
module pam4_prbs_rx #(
  parameter int NSYM = 8,
  parameter int PLEN = 7,
  parameter int TAP  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [NSYM-1:0]   thr_lo,
  input  logic [NSYM-1:0]   thr_mid,
  input  logic [NSYM-1:0]   thr_hi,
  output logic [2*NSYM-1:0] level_o,
  output logic              err_o
);
  localparam int NBIT = 2 * NSYM;
  localparam int SLEN = PLEN + NBIT;
  localparam int DIST = PLEN - TAP;

  logic [NBIT-1:0] lvl;
  logic [NSYM-1:0] bubble;
  logic [SLEN-1:0] st;
  logic [NBIT-1:0] mis;
  logic [PLEN-1:0] hist_q;
  logic            vprev_q;

  assign st[PLEN-1:0] = hist_q;

  genvar k, j;
  generate
    for (k = 0; k < NSYM; k++) begin : g_sym
      assign lvl[2*k+:2] = {1'b0, thr_lo[k]} + {1'b0, thr_mid[k]} + {1'b0, thr_hi[k]};
      assign bubble[k]   = (thr_hi[k] & ~thr_mid[k]) | (thr_mid[k] & ~thr_lo[k]);
      assign st[PLEN+2*k]   = lvl[2*k+1];
      assign st[PLEN+2*k+1] = lvl[2*k];
    end
    for (j = 0; j < NBIT; j++) begin : g_chk
      assign mis[j] = st[PLEN+j] ^ st[j] ^ st[j+DIST];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      vprev_q <= 1'b0;
      level_o <= '0;
      err_o   <= 1'b0;
    end else begin
      vprev_q <= valid;
      err_o   <= valid & vprev_q & ((|mis) | (|bubble));
      if (valid) begin
        level_o <= lvl;
        hist_q  <= st[SLEN-1:NBIT];
      end
    end
  end
endmodule

module pam4_prbs_rx_chk #(
  parameter int NSYM = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic [NSYM-1:0]   thr_lo,
  input logic [NSYM-1:0]   thr_mid,
  input logic [NSYM-1:0]   thr_hi,
  input logic [2*NSYM-1:0] level_o,
  input logic              err_o
);
  logic has_bubble;
  assign has_bubble = |((thr_hi & ~thr_mid) | (thr_mid & ~thr_lo));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !err_o);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(level_o));

  // R6
  first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !$past(valid)) |=> !err_o);

  // R2
  bubble_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && has_bubble) |=> err_o);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (level_o == '0 && !err_o));
endmodule

bind pam4_prbs_rx pam4_prbs_rx_chk #(.NSYM(NSYM)) chk_i (
  .clk(clk), .rst_n(rst_n), .valid(valid),
  .thr_lo(thr_lo), .thr_mid(thr_mid), .thr_hi(thr_hi),
  .level_o(level_o), .err_o(err_o)
);

// File: tb/pam4_prbs_rx_tb.sv
module pam4_prbs_rx_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, valid;
  logic [7:0]  lo, mid, hi;
  logic [15:0] level;
  logic        err;

  int checks = 0;
  int errors = 0;

  bit          mh[7];
  bit          mvp;
  bit          g[7];
  logic [15:0] exp_lvl;
  bit          exp_err;

  pam4_prbs_rx dut_i (
    .clk(clk), .rst_n(rst_n), .valid(valid),
    .thr_lo(lo), .thr_mid(mid), .thr_hi(hi),
    .level_o(level), .err_o(err)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic gen16(output logic [15:0] sb);
    for (int j = 0; j < 16; j++) begin
      bit nb;
      nb = g[0] ^ g[1];
      for (int i = 0; i < 6; i++) g[i] = g[i+1];
      g[6] = nb;
      sb[j] = nb;
    end
  endtask

  task automatic ser2thr(input logic [15:0] sb, output logic [7:0] l, output logic [7:0] m, output logic [7:0] h);
    for (int k = 0; k < 8; k++) begin
      int lv;
      lv = 2 * int'(sb[2*k]) + int'(sb[2*k+1]);
      l[k] = (lv >= 1);
      m[k] = (lv >= 2);
      h[k] = (lv == 3);
    end
  endtask

  task automatic model();
    bit st[23];
    bit bad;
    if (valid) begin
      bad = 0;
      for (int i = 0; i < 7; i++) st[i] = mh[i];
      for (int k = 0; k < 8; k++) begin
        int lv;
        logic [2:0] p;
        p = {hi[k], mid[k], lo[k]};
        if (!(p == 3'b000 || p == 3'b001 || p == 3'b011 || p == 3'b111)) bad = 1;
        lv = int'(lo[k]) + int'(mid[k]) + int'(hi[k]);
        exp_lvl[2*k+:2] = lv[1:0];
        st[7+2*k] = lv[1];
        st[8+2*k] = lv[0];
      end
      for (int j = 0; j < 16; j++)
        if (st[7+j] != (st[j] ^ st[j+1])) bad = 1;
      exp_err = mvp & bad;
      for (int i = 0; i < 7; i++) mh[i] = st[16+i];
    end else begin
      exp_err = 0;
    end
    mvp = valid;
  endtask

  task automatic cyc(input bit v, input logic [7:0] l, input logic [7:0] m, input logic [7:0] h, input string tag);
    valid = v; lo = l; mid = m; hi = h;
    model();
    @(negedge clk);
    check(level === exp_lvl, {tag, " level"}, level, exp_lvl);
    check(err === exp_err, {tag, " err"}, {15'd0, err}, {15'd0, exp_err});
  endtask

  task automatic prbs_cyc(input int flip, input string tag);
    logic [15:0] sb;
    logic [7:0] l, m, h;
    gen16(sb);
    if (flip >= 0) sb[flip] = ~sb[flip];
    ser2thr(sb, l, m, h);
    cyc(1'b1, l, m, h, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] sb;
    logic [7:0] l, m, h;
    void'($urandom(1234));
    for (int i = 0; i < 7; i++) g[i] = 1'b1;
    for (int i = 0; i < 7; i++) mh[i] = 1'b0;
    mvp = 0; exp_lvl = '0; exp_err = 0;
    rst_n = 1'b0; valid = 1'b0; lo = '1; mid = '1; hi = '1;
    repeat (3) @(negedge clk);
    // R8
    check(level === 16'h0000, "R8 reset level", level, 16'h0000);
    check(err === 1'b0, "R8 reset err", {15'd0, err}, 16'h0000);
    lo = '0; mid = '0; hi = '0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1 all four levels, R6 first valid after reset is not flagged
    cyc(1'b1, 8'b11101110, 8'b11001100, 8'b10001000, "R1 R6 levels");
    check(level === 16'hE4E4, "R1 mapping", level, 16'hE4E4);
    check(err === 1'b0, "R6 first after reset", {15'd0, err}, 16'h0000);

    // R7 and R3 idle cycle with other inputs
    cyc(1'b0, 8'h5A, 8'hC3, 8'h0F, "R7 R3 idle");
    check(level === 16'hE4E4, "R3 hold", level, 16'hE4E4);

    // R6 rise after gap with out-of-sequence data, R5 clean stream
    prbs_cyc(-1, "R6 rise");
    for (int c = 0; c < 6; c++) prbs_cyc(-1, "R5 clean");
    check(err === 1'b0, "R5 clean err", {15'd0, err}, 16'h0000);

    // R4 flip mid cycle
    prbs_cyc(10, "R4 flip10");
    check(err === 1'b1, "R4 flip detected", {15'd0, err}, 16'h0001);
    for (int c = 0; c < 3; c++) prbs_cyc(-1, "R4 resync");
    // R4 flip at first bit of a cycle: needs history across the boundary
    prbs_cyc(0, "R4 flip0");
    check(err === 1'b1, "R4 boundary flip", {15'd0, err}, 16'h0001);
    for (int c = 0; c < 3; c++) prbs_cyc(-1, "R4 resync");

    // R2 bubble 010 on symbol 3 of clean data
    gen16(sb);
    ser2thr(sb, l, m, h);
    l[3] = 1'b0; m[3] = 1'b1; h[3] = 1'b0;
    cyc(1'b1, l, m, h, "R2 bubble");
    check(level[7:6] === 2'b01, "R2 popcount", {14'd0, level[7:6]}, 16'h0001);
    check(err === 1'b1, "R2 flag", {15'd0, err}, 16'h0001);

    // R6 bubble on the rise cycle is not flagged
    cyc(1'b0, 8'h00, 8'h00, 8'h00, "R7 gap");
    cyc(1'b1, 8'h00, 8'hFF, 8'h00, "R6 rise bubble");
    check(err === 1'b0, "R6 rise suppress", {15'd0, err}, 16'h0000);

    // random mix covering R1 R2 R3 R4 R5 R6 R7
    for (int c = 0; c < 1500; c++) begin
      bit v;
      v = ($urandom_range(0, 9) != 0);
      gen16(sb);
      if ($urandom_range(0, 7) == 0) sb[$urandom_range(0, 15)] ^= 1'b1;
      ser2thr(sb, l, m, h);
      if ($urandom_range(0, 9) == 0) begin
        int k;
        logic [2:0] p;
        k = $urandom_range(0, 7);
        case ($urandom_range(0, 3))
          0: p = 3'b010;
          1: p = 3'b100;
          2: p = 3'b101;
          default: p = 3'b110;
        endcase
        {h[k], m[k], l[k]} = p;
      end
      cyc(v, l, m, h, "R1/R2/R4/R6/R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule